// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns two external interrupt pins into interrupt requests for a processor core. Each line has its own two-bit sense code. The code selects one of four detection modes: low level, any change, falling edge or rising edge. In the three event modes, a detected event sets a per-line pending flag. The flag holds until software writes a one to it or the core acknowledges the service of that line. In low-level mode the flag is forced to zero, and the request follows the synchronized pin directly.

A line's request reaches the core only when the line enable and the global interrupt enable input are both set. Pins are sampled through a synchronizer, so the block still sees activity when the same device drives the pin as an output. Software can use this to raise an interrupt on its own.

A clock-free wake output is formed from the raw pin for lines in low-level mode. A small register port holds the sense codes and enables at address 0 and the flags at address 1.

Top module: `eisc_top`

## Requirements
- R1: After a synchronous reset the control register reads zero and the flag register reads zero. Both requests are low. All lines are therefore in low-level mode and disabled.
- R2: Sense code 00 selects low level, 01 any change, 10 falling edge and 11 rising edge. At address 0, line i's code is held in bits [2i+1:2i] and its enable in bit 2N+i (bits 4 and 5 when N=2). Unused bits read zero. At address 1, bit i is line i's flag.
- R3: In an event mode, a matching pin transition sets the line's flag. The flag can be read as set after the third rising clock edge following the pin change.
- R4: In a single-edge mode, a transition of the opposite polarity leaves the flag clear.
- R5: A register write to address 1 clears each flag whose data bit is one. Flags whose data bit is zero are unchanged.
- R6: A one-cycle pulse on a line's acknowledge input clears that line's flag.
- R7: If an event and a clear (acknowledge or write-one) fall in the same cycle, the flag ends up set.
- R8: In low-level mode the flag stays zero. The request is high while the synchronized pin is low, the line is enabled and the global enable is set.
- R9: A request is asserted only when the line enable and the global enable input are both one. A pending flag is kept while either enable is off.
- R10: Rewriting a line's sense code while its pin is steady does not set the flag.
- R11: The wake output of a line is high, without any clock edge, when the raw pin is low, the line is enabled and it is in low-level mode. The global enable plays no part in it.
- R12: Each line's detection, flag and request are independent of the other line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 2 | Raw external interrupt pins, one per line |
| gie_i | input | 1 | Global interrupt enable from the core |
| ack_i | input | 2 | Per-line service acknowledge, clears the flag |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register address: 0 control, 1 flags |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| irq_o | output | 2 | Per-line interrupt request to the core |
| wake_o | output | 2 | Clock-free low-level wake indication per line |

## Verification
The hardest case to reach is an event and a clear landing in the same clock cycle. The synchronizer delay hides the cycle in which the edge is recognised. The bench counts edges from the pin change: it drives the pin, waits two rising edges, then pulses acknowledge for exactly the third cycle, when the edge detector fires. A design that lets the clear win leaves the flag zero. The table of vectors then walks every sense code, both polarities, gated enables and mixed modes across the two lines.

// File: rtl/eisc_pkg.sv
package eisc_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef struct packed {
        sense_e sense;
        logic   en;
    } line_cfg_t;

    localparam int unsigned SENSE_W = 2;

    function automatic logic sense_hit(sense_e mode, logic prev, logic cur);
        logic hit;
        case (mode)
            SENSE_ANY:  hit = prev ^ cur;
            SENSE_FALL: hit = prev & ~cur;
            SENSE_RISE: hit = ~prev & cur;
            default:    hit = 1'b0;
        endcase
        return hit;
    endfunction

    function automatic logic is_level(sense_e mode);
        return mode == SENSE_LOW;
    endfunction

endpackage

// File: rtl/eisc_sync.sv
module eisc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/eisc_line.sv
module eisc_line
    import eisc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_raw_i,
    input  line_cfg_t cfg_i,
    input  logic      gie_i,
    input  logic      clr_i,
    output logic      flag_o,
    output logic      irq_o,
    output logic      wake_o
);
    logic pin_s;
    logic prev_q;
    logic evt;
    logic flag_q;
    logic flag_d;

    eisc_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i (pin_raw_i),
        .q_o (pin_s)
    );

    // previous sample tracks the pin in every mode, so mode changes see no edge
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= pin_s;
    end

    assign evt = sense_hit(cfg_i.sense, prev_q, pin_s);

    always_comb begin
        if (is_level(cfg_i.sense)) flag_d = 1'b0;
        else if (evt)              flag_d = 1'b1;
        else if (clr_i)            flag_d = 1'b0;
        else                       flag_d = flag_q;
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= flag_d;
    end

    assign flag_o = flag_q;
    assign irq_o  = cfg_i.en & gie_i &
                    (is_level(cfg_i.sense) ? ~pin_s : flag_q);
    assign wake_o = cfg_i.en & is_level(cfg_i.sense) & ~pin_raw_i;

    assert_level_flag_zero_R8: assert property (@(posedge clk) disable iff (rst)
        is_level(cfg_i.sense) |=> !flag_q);

    assert_event_sets_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (!is_level(cfg_i.sense) && evt) |=> flag_q);

    assert_clear_drops_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !evt) |=> !flag_q);

    assert_coincident_set_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_i && evt && !is_level(cfg_i.sense)) |=> flag_q);
endmodule

// File: rtl/eisc_regs.sv
module eisc_regs
    import eisc_pkg::*;
#(
    parameter int unsigned LINES  = 2,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [LINES-1:0]  flags_i,
    output logic [DATA_W-1:0] rdata_o,
    output line_cfg_t         cfg_o [LINES],
    output logic [LINES-1:0]  wclr_o
);
    localparam int unsigned EN_BASE   = SENSE_W * LINES;
    localparam int unsigned CTRL_BITS = EN_BASE + LINES;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(1);
    localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'((1 << CTRL_BITS) - 1);

    logic [DATA_W-1:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (rst)                             ctrl_q <= '0;
        else if (we_i && addr_i == CTRL_ADDR) ctrl_q <= wdata_i & CTRL_MASK;
    end

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_cfg
            assign cfg_o[i].sense = sense_e'(ctrl_q[SENSE_W*i +: SENSE_W]);
            assign cfg_o[i].en    = ctrl_q[EN_BASE + i];
            assign wclr_o[i]      = we_i && (addr_i == FLAG_ADDR) && wdata_i[i];
        end
    endgenerate

    always_comb begin
        case (addr_i)
            CTRL_ADDR: rdata_o = ctrl_q;
            FLAG_ADDR: rdata_o = DATA_W'(flags_i);
            default:   rdata_o = '0;
        endcase
    end

    assert_ctrl_unused_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q & ~CTRL_MASK) == '0);
endmodule

// File: rtl/eisc_top.sv
module eisc_top
    import eisc_pkg::*;
#(
    parameter int unsigned LINES       = 2,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned ADDR_W      = 1,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINES-1:0]  pin_i,
    input  logic              gie_i,
    input  logic [LINES-1:0]  ack_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic [LINES-1:0]  irq_o,
    output logic [LINES-1:0]  wake_o
);
    line_cfg_t        cfg [LINES];
    logic [LINES-1:0] flags;
    logic [LINES-1:0] wclr;

    eisc_regs #(
        .LINES  (LINES),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) regs_i (
        .clk     (clk),
        .rst     (rst),
        .we_i    (reg_we_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .flags_i (flags),
        .rdata_o (reg_rdata_o),
        .cfg_o   (cfg),
        .wclr_o  (wclr)
    );

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_line
            eisc_line #(.SYNC_STAGES(SYNC_STAGES)) line_i (
                .clk       (clk),
                .rst       (rst),
                .pin_raw_i (pin_i[i]),
                .cfg_i     (cfg[i]),
                .gie_i     (gie_i),
                .clr_i     (wclr[i] | ack_i[i]),
                .flag_o    (flags[i]),
                .irq_o     (irq_o[i]),
                .wake_o    (wake_o[i])
            );

            assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
                irq_o[i] |-> (gie_i && cfg[i].en));

            assert_wake_level_only_R11: assert property (@(posedge clk) disable iff (rst)
                wake_o[i] |-> (cfg[i].en && cfg[i].sense == SENSE_LOW && !pin_i[i]));
        end
    endgenerate

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (irq_o == '0 && flags == '0));
endmodule

// File: tb/eisc_top_tb_top.sv
`timescale 1ns/1ps
module eisc_top_tb_top;
    localparam int unsigned LINES = 2;
    localparam int unsigned DW    = 8;

    typedef struct packed {
        logic [7:0] ctrl;
        logic [1:0] pin_start;
        logic [1:0] pin_end;
        logic       gie;
        logic [1:0] exp_flags;
        logic [1:0] exp_irq;
    } vec_t;

    // ctrl: [1:0] line0 code, [3:2] line1 code, [4] en0, [5] en1
    localparam vec_t VECS [8] = '{
        '{8'h3E, 2'b01, 2'b10, 1'b1, 2'b11, 2'b11}, // R3 R12 fall/rise match
        '{8'h3E, 2'b10, 2'b01, 1'b1, 2'b00, 2'b00}, // R4 opposite polarity
        '{8'h35, 2'b00, 2'b11, 1'b0, 2'b11, 2'b00}, // R9 any-change, gie off
        '{8'h35, 2'b11, 2'b01, 1'b1, 2'b10, 2'b10}, // R12 only line1 changes
        '{8'h30, 2'b11, 2'b10, 1'b1, 2'b00, 2'b01}, // R8 level mode
        '{8'h10, 2'b11, 2'b00, 1'b1, 2'b00, 2'b01}, // R9 line1 disabled
        '{8'h03, 2'b00, 2'b01, 1'b1, 2'b01, 2'b00}, // R9 flag kept, no enable
        '{8'h38, 2'b11, 2'b00, 1'b1, 2'b10, 2'b11}  // R12 mixed level/fall
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [LINES-1:0] pin = '0;
    logic            gie = 1'b0;
    logic [LINES-1:0] ack = '0;
    logic            we = 1'b0;
    logic [0:0]      addr = '0;
    logic [DW-1:0]   wdata = '0;
    logic [DW-1:0]   rdata;
    logic [LINES-1:0] irq;
    logic [LINES-1:0] wake;

    int unsigned checks = 0;
    int unsigned errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    eisc_top dut_i (
        .clk         (clk),
        .rst         (rst),
        .pin_i       (pin),
        .gie_i       (gie),
        .ack_i       (ack),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq),
        .wake_o      (wake)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic a, logic [7:0] d);
        addr = a; wdata = d; we = 1'b1;
        tick(1);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(logic a, output logic [7:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        @(negedge clk);
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        rd(1'b0, r); check("R1 ctrl after reset", r, 8'h00);
        rd(1'b1, r); check("R1 flags after reset", r, 8'h00);
        check("R1 irq after reset", {6'b0, irq}, 8'h00);

        // R2 layout and unused bits
        wr(1'b0, 8'hFF);
        rd(1'b0, r); check("R2 ctrl unused bits zero", r, 8'h3F);

        // table walk
        for (int v = 0; v < 8; v++) begin
            pin = VECS[v].pin_start;
            gie = VECS[v].gie;
            wr(1'b0, VECS[v].ctrl);
            tick(4);
            wr(1'b1, 8'h03);
            pin = VECS[v].pin_end;
            tick(4);
            rd(1'b1, r);
            check($sformatf("R3/R4/R8/R12 vec%0d flags", v), r, {6'b0, VECS[v].exp_flags});
            check($sformatf("R8/R9/R12 vec%0d irq", v), {6'b0, irq}, {6'b0, VECS[v].exp_irq});
        end

        // R5 write zero keeps, write one clears
        pin = 2'b00; gie = 1'b1;
        wr(1'b0, 8'h13);
        tick(4);
        wr(1'b1, 8'h03);
        pin = 2'b01;
        tick(4);
        wr(1'b1, 8'h02);
        rd(1'b1, r); check("R5 write zero keeps flag", r, 8'h01);
        wr(1'b1, 8'h01);
        rd(1'b1, r); check("R5 write one clears flag", r, 8'h00);

        // R6 acknowledge clears
        pin = 2'b00;
        tick(4);
        pin = 2'b01;
        tick(4);
        rd(1'b1, r); check("R6 flag set before ack", r, 8'h01);
        ack = 2'b01; tick(1); ack = 2'b00;
        rd(1'b1, r); check("R6 ack clears flag", r, 8'h00);

        // R7 ack coincident with event detection cycle
        pin = 2'b00;
        tick(4);
        wr(1'b1, 8'h03);
        pin = 2'b01;
        @(posedge clk); @(posedge clk); @(negedge clk);
        ack = 2'b01;
        tick(1);
        ack = 2'b00;
        rd(1'b1, r); check("R7 event wins over ack", r, 8'h01);

        // R10 code rewrites with pin steady high
        wr(1'b1, 8'h03);
        wr(1'b0, 8'h12);
        tick(3);
        wr(1'b0, 8'h11);
        tick(3);
        wr(1'b0, 8'h13);
        tick(3);
        rd(1'b1, r); check("R10 code change sets no flag", r, 8'h00);

        // R11 wake is clock-free and ignores gie
        gie = 1'b0;
        wr(1'b0, 8'h10);
        pin = 2'b01;
        #0.5; check("R11 wake low while pin high", {6'b0, wake}, 8'h00);
        pin = 2'b00;
        #0.5; check("R11 wake follows raw pin", {6'b0, wake}, 8'h01);
        @(negedge clk);
        wr(1'b0, 8'h12);
        check("R11 no wake in edge mode", {6'b0, wake}, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule